// File: doc/BRIEF.md
# Multidrop Packet Decoder With 3-Bit CRC

This block sits behind a UART byte receiver on a shared serial bus, where one controller talks to up to sixteen devices. After the receiver reports a valid synchronization frame, the decoder takes the following bytes, each delivered with its own parity, stop and start error flags. It tells write packets from read packets and decides whether the packet is meant for this device. The address can be an individual device, every device on the bus, or a programmable group. The decoder then checks the 3-bit checksum that closes the packet.

A write that passes all checks leaves the block as a one-cycle 13-bit register write request. A read that passes leaves as a one-cycle read request. The register file returns the data in the same cycle, and the decoder then queues a three-byte reply for the serializer. An individual write is answered with a single acknowledge byte. Broadcast and group writes get no answer at all. Sticky error bits record checksum, parity, stop, start and inter-frame silence faults, and each is cleared by writing 1 to it.

Top module: `mdrop_pkt_decoder`

## Requirements
- R1: After reset, no write or read request and no reply byte is issued, all five error bits read 0, and the decoder waits for a synchronization pulse.
- R2: The address byte is decoded as group flag in bit 7, target ID in bits 6:1 and direction in bit 0 (0 = write, 1 = read). With the flag clear, the packet is for this device only when the target ID equals the 4-bit device ID zero-extended to 6 bits.
- R3: A write packet is sync, address, register byte, low data byte, then a final byte with data bits 12:8 in bits 7:3 and the checksum in bits 2:0. When it is accepted, wr_en is high for exactly the one cycle after the final byte is sampled, with wr_addr set to the register byte and wr_data set to {final[7:3], low byte}.
- R4: The checksum uses x^3+x+1 with a seed of 000. It covers the address byte, the register byte, the low data byte (writes only) and final-byte bits 7:3, each taken LSB first. On a mismatch nothing is requested or answered, and error bit 0 is set.
- R5: A write with the flag set and target ID 0 is committed and gets no reply.
- R6: A write with the flag set and target ID equal to cluster_id is committed and gets no reply. A flagged write whose ID matches neither 0 nor cluster_id is ignored.
- R7: An accepted individual write is answered with the single byte 0xC3.
- R8: A read packet is sync, address, register byte, then a final byte with zero data bits and the checksum. When it is accepted, rd_req is high for one cycle with rd_addr set to the register byte, and rd_data is sampled in that cycle. The reply is 0xC3, rd_data[7:0], then {rd_data[12:8], crc}, where crc is taken over rd_data bits 0..12 in that order.
- R9: A read with the flag set, or with a target ID that is not this device, produces no request and no reply.
- R10: A byte that arrives mid-packet with its parity, stop or start flag set sets error bit 1, 2 or 3 respectively. The packet is dropped, and bytes are ignored until the next synchronization pulse.
- R11: Mid-packet, the 17th bit_tick with no byte since the last one sets error bit 4 and drops the packet. 16 ticks do not.
- R12: Writing 1 to a bit of err_clr clears only that error bit. A new error in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_ok | input | 1 | Pulse: valid synchronization frame received |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| byte_perr | input | 1 | Parity error on this byte |
| byte_stop_err | input | 1 | Stop bit error on this byte |
| byte_start_err | input | 1 | Start bit error on this byte |
| bit_tick | input | 1 | One pulse per bit time |
| dev_id | input | 4 | Strap-set device ID |
| cluster_id | input | 6 | Stored group ID |
| err_clr | input | 5 | Write-1-to-clear for the error bits |
| rd_data | input | 13 | Register read data, valid while rd_req is high |
| rsp_ready | input | 1 | Serializer accepts the current reply byte |
| wr_en | output | 1 | Register write request |
| wr_addr | output | 8 | Write register address |
| wr_data | output | 13 | Write data |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 8 | Read register address |
| rsp_vld | output | 1 | Reply byte available |
| rsp_byte | output | 8 | Reply byte |
| err_flags | output | 5 | Sticky errors: 0 checksum, 1 parity, 2 stop, 3 start, 4 silence |

## Verification
A frame state that has slipped shows up one byte later. The final byte is then read as data, so a valid packet is either not committed or committed with the wrong fields and wrong flags. A corrupted running checksum turns into a false bit-0 error at the end of that packet. A faulty reply queue shows within three cycles of the request, as a missing acknowledge byte, a reply to a group write, or a wrong third byte. A silence counter that fails to clear between bytes raises bit 4 in a long but legal gap.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int DATA_W   = 13;
  localparam int NUM_ERR  = 5;
  localparam int EB_CRC   = 0;
  localparam int EB_PAR   = 1;
  localparam int EB_STOP  = 2;
  localparam int EB_START = 3;
  localparam int EB_SIL   = 4;
  localparam logic [7:0] ACK_CODE = 8'hC3;

  typedef enum logic [2:0] {ST_SYNC, ST_ADDR, ST_REG, ST_DLO, ST_FIN} pst_e;

  // serial CRC x^3+x+1, bits consumed from d[0] upward, n bits
  function automatic logic [2:0] crc3_upd(input logic [2:0] c, input logic [DATA_W-1:0] d,
                                          input int n);
    logic [2:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        fb = d[i] ^ r[2];
        r  = {r[1], r[0] ^ fb, fb};
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pdec_errflags.sv
module pdec_errflags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~clr_i) | set_i;
  end

  assign flags_o = err_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & ~clr_i) != '0) |=> ((err_q & $past(err_q & ~clr_i)) == $past(err_q & ~clr_i))); // R12
endmodule

// File: rtl/pdec_parser.sv
module pdec_parser
  import pdec_pkg::*;
#(
  parameter int DEV_W   = 4,
  parameter int ID_W    = 6,
  parameter int TO_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_ok,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_perr,
  input  logic              byte_stop_err,
  input  logic              byte_start_err,
  input  logic              bit_tick,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic [ID_W-1:0]   cluster_id,
  output logic              wr_en,
  output logic [7:0]        wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [7:0]        rd_addr,
  output logic              ack_req,
  output logic [NUM_ERR-1:0] err_set
);
  localparam int TO_W = $clog2(TO_BITS + 1);

  pst_e            st_q, st_d;
  logic [7:0]      adr_q, reg_q, dlo_q;
  logic [2:0]      crc_q, crc_calc;
  logic [TO_W-1:0] sil_q;

  // named events for the assertions and outputs
  logic in_pkt, frame_err, sil_evt, good_byte, fin_evt, crc_ok;
  logic grp, is_rd, hit_ind, hit_glb, hit_cl, commit_wr, commit_rd;
  logic [ID_W-1:0] tid;

  assign in_pkt    = (st_q != ST_SYNC);
  assign frame_err = byte_vld && in_pkt && (byte_perr || byte_stop_err || byte_start_err);
  assign sil_evt   = in_pkt && !byte_vld && bit_tick && (sil_q == TO_W'(TO_BITS));
  assign good_byte = byte_vld && in_pkt && !frame_err;
  assign fin_evt   = good_byte && (st_q == ST_FIN);
  assign crc_calc  = crc3_upd(crc_q, {8'b0, byte_data[7:3]}, 5);
  assign crc_ok    = (crc_calc == byte_data[2:0]);

  assign grp     = adr_q[7];
  assign tid     = adr_q[6:1];
  assign is_rd   = adr_q[0];
  assign hit_ind = !grp && (tid == {{(ID_W-DEV_W){1'b0}}, dev_id});
  assign hit_glb = grp && (tid == '0) && !is_rd;
  assign hit_cl  = grp && (tid == cluster_id) && !is_rd;

  assign commit_wr = fin_evt && crc_ok && !is_rd && (hit_ind || hit_glb || hit_cl);
  assign commit_rd = fin_evt && crc_ok && is_rd && hit_ind;

  always_comb begin
    err_set           = '0;
    err_set[EB_CRC]   = fin_evt && !crc_ok;
    err_set[EB_PAR]   = frame_err && byte_perr;
    err_set[EB_STOP]  = frame_err && byte_stop_err;
    err_set[EB_START] = frame_err && byte_start_err;
    err_set[EB_SIL]   = sil_evt;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_SYNC: if (sync_ok)   st_d = ST_ADDR;
      ST_ADDR: if (good_byte) st_d = ST_REG;
      ST_REG:  if (good_byte) st_d = adr_q[0] ? ST_FIN : ST_DLO;
      ST_DLO:  if (good_byte) st_d = ST_FIN;
      ST_FIN:  if (good_byte) st_d = ST_SYNC;
      default: st_d = ST_SYNC;
    endcase
    if (frame_err || sil_evt) st_d = ST_SYNC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_SYNC;
      adr_q   <= '0;
      reg_q   <= '0;
      dlo_q   <= '0;
      crc_q   <= '0;
      sil_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      ack_req <= 1'b0;
    end else begin
      st_q <= st_d;
      if (!in_pkt || byte_vld)                           sil_q <= '0;
      else if (bit_tick && sil_q != TO_W'(TO_BITS))      sil_q <= sil_q + 1'b1;
      if (good_byte) begin
        case (st_q)
          ST_ADDR: begin adr_q <= byte_data; crc_q <= crc3_upd(3'b000, {5'b0, byte_data}, 8); end
          ST_REG:  begin reg_q <= byte_data; crc_q <= crc3_upd(crc_q, {5'b0, byte_data}, 8); end
          ST_DLO:  begin dlo_q <= byte_data; crc_q <= crc3_upd(crc_q, {5'b0, byte_data}, 8); end
          default: ;
        endcase
      end
      wr_en   <= commit_wr;
      rd_req  <= commit_rd;
      ack_req <= commit_wr && hit_ind;
      if (commit_wr) begin
        wr_addr <= reg_q;
        wr_data <= {byte_data[7:3], dlo_q};
      end
      if (commit_rd) rd_addr <= reg_q;
    end
  end

  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err || sil_evt) |=> (st_q == ST_SYNC && !wr_en && !rd_req)); // R10
  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req)); // R3
  AST_SIL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    sil_evt |=> !in_pkt); // R11
endmodule

// File: rtl/pdec_resp.sv
module pdec_resp
  import pdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rsp_ready,
  output logic              rsp_vld,
  output logic [7:0]        rsp_byte
);
  logic [1:0] n_q, i_q;
  logic [7:0] lo_q, hi_q;

  assign rsp_vld = (i_q < n_q);

  always_comb begin
    case (i_q)
      2'd0:    rsp_byte = ACK_CODE;
      2'd1:    rsp_byte = lo_q;
      default: rsp_byte = hi_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q  <= '0;
      i_q  <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (rd_i) begin
      n_q  <= 2'd3;
      i_q  <= 2'd0;
      lo_q <= rd_data_i[7:0];
      hi_q <= {rd_data_i[DATA_W-1:8], crc3_upd(3'b000, rd_data_i, DATA_W)};
    end else if (ack_i) begin
      n_q <= 2'd1;
      i_q <= 2'd0;
    end else if (rsp_vld && rsp_ready) begin
      i_q <= i_q + 1'b1;
    end
  end

  AST_REPLY_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_vld) |-> $past(ack_i || rd_i)); // R7
  AST_ACK_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_vld) |-> (rsp_byte == ACK_CODE)); // R8
endmodule

// File: rtl/mdrop_pkt_decoder.sv
module mdrop_pkt_decoder
  import pdec_pkg::*;
#(
  parameter int DEV_W   = 4,
  parameter int ID_W    = 6,
  parameter int TO_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_ok,
  input  logic               byte_vld,
  input  logic [7:0]         byte_data,
  input  logic               byte_perr,
  input  logic               byte_stop_err,
  input  logic               byte_start_err,
  input  logic               bit_tick,
  input  logic [DEV_W-1:0]   dev_id,
  input  logic [ID_W-1:0]    cluster_id,
  input  logic [NUM_ERR-1:0] err_clr,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               rsp_ready,
  output logic               wr_en,
  output logic [7:0]         wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               rd_req,
  output logic [7:0]         rd_addr,
  output logic               rsp_vld,
  output logic [7:0]         rsp_byte,
  output logic [NUM_ERR-1:0] err_flags
);
  logic               ack_req;
  logic [NUM_ERR-1:0] err_set;

  pdec_parser #(.DEV_W(DEV_W), .ID_W(ID_W), .TO_BITS(TO_BITS)) u_parse (
    .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_perr(byte_perr), .byte_stop_err(byte_stop_err),
    .byte_start_err(byte_start_err), .bit_tick(bit_tick), .dev_id(dev_id),
    .cluster_id(cluster_id), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .ack_req(ack_req), .err_set(err_set)
  );

  pdec_resp u_resp (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_req), .rd_i(rd_req), .rd_data_i(rd_data),
    .rsp_ready(rsp_ready), .rsp_vld(rsp_vld), .rsp_byte(rsp_byte)
  );

  pdec_errflags #(.N(NUM_ERR)) u_err (
    .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .flags_o(err_flags)
  );
endmodule

// File: tb/tb_mdrop_pkt_decoder.sv
module tb_mdrop_pkt_decoder;
  localparam logic [3:0] DEV = 4'h5;
  localparam logic [5:0] CL  = 6'h2A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sync_ok, byte_vld, byte_perr, byte_stop_err, byte_start_err, bit_tick, rsp_ready;
  logic [7:0] byte_data;
  logic [4:0] err_clr;
  logic [12:0] rd_data;
  logic wr_en, rd_req, rsp_vld;
  logic [7:0] wr_addr, rd_addr, rsp_byte;
  logic [12:0] wr_data;
  logic [4:0] err_flags;

  int checks = 0, errors = 0;
  logic [7:0] cap [0:7];
  int ncap = 0;

  function automatic logic [12:0] mem_val(input logic [7:0] a);
    return {a[4:0], a ^ 8'h5A};
  endfunction
  assign rd_data = mem_val(rd_addr);

  mdrop_pkt_decoder dut (
    .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_perr(byte_perr), .byte_stop_err(byte_stop_err), .byte_start_err(byte_start_err),
    .bit_tick(bit_tick), .dev_id(DEV), .cluster_id(CL), .err_clr(err_clr), .rd_data(rd_data),
    .rsp_ready(rsp_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rsp_vld(rsp_vld), .rsp_byte(rsp_byte),
    .err_flags(err_flags)
  );

  always @(negedge clk) begin
    if (rst_n && rsp_vld && rsp_ready) begin
      if (ncap < 8) cap[ncap] = rsp_byte;
      ncap++;
    end
  end

  // reference checksum by polynomial long division, first bit = highest power
  function automatic logic [2:0] ref_crc(input logic [31:0] bits, input int n);
    logic [3:0] r = 4'b0;
    for (int i = 0; i < n + 3; i++) begin
      r = {r[2:0], (i < n) ? bits[i] : 1'b0};
      if (r[3]) r = r ^ 4'b1011;
    end
    return r[2:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit pe = 0, input bit se = 0, input bit ste = 0);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b; byte_perr = pe; byte_stop_err = se; byte_start_err = ste;
    @(negedge clk);
    byte_vld = 1'b0; byte_perr = 1'b0; byte_stop_err = 1'b0; byte_start_err = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); sync_ok = 1'b1;
    @(negedge clk); sync_ok = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); err_clr = 5'h1F;
    @(negedge clk); err_clr = 5'h00;
  endtask

  task automatic run_pkt(input logic [7:0] adr, input logic [7:0] ra, input logic [12:0] d,
                         input bit bad, input string tag);
    logic [31:0] bits;
    int n;
    bit rd, grp, exp_wr, exp_rd, exp_ack;
    logic [5:0] id;
    logic [2:0] c, rc;
    logic [4:0] hi;
    int exp_n;
    rd = adr[0]; grp = adr[7]; id = adr[6:1];
    hi = rd ? 5'b0 : d[12:8];
    bits = '0;
    bits[7:0] = adr; bits[15:8] = ra;
    if (rd) begin bits[20:16] = hi; n = 21; end
    else begin bits[23:16] = d[7:0]; bits[28:24] = hi; n = 29; end
    c = ref_crc(bits, n);
    if (bad) c = c ^ 3'b001;
    exp_wr  = !bad && !rd && ((!grp && id == {2'b0, DEV}) || (grp && id == 6'd0) || (grp && id == CL));
    exp_rd  = !bad && rd && !grp && id == {2'b0, DEV};
    exp_ack = exp_wr && !grp;
    ncap = 0;
    do_sync();
    send_byte(adr);
    send_byte(ra);
    if (!rd) send_byte(d[7:0]);
    send_byte({hi, c});
    check(wr_en == exp_wr, {tag, " R3 wr_en"}, wr_en, exp_wr);
    if (exp_wr) begin
      check(wr_addr == ra, {tag, " R3 wr_addr"}, wr_addr, ra);
      check(wr_data == d, {tag, " R3 wr_data"}, wr_data, d);
    end
    check(rd_req == exp_rd, {tag, " R8 rd_req"}, rd_req, exp_rd);
    if (exp_rd) check(rd_addr == ra, {tag, " R8 rd_addr"}, rd_addr, ra);
    check(err_flags[0] == bad, {tag, " R4 crc flag"}, err_flags, bad);
    repeat (6) @(negedge clk);
    exp_n = exp_rd ? 3 : (exp_ack ? 1 : 0);
    check(ncap == exp_n, {tag, " R7 reply count"}, ncap, exp_n);
    if (exp_n >= 1 && ncap >= 1) check(cap[0] == 8'hC3, {tag, " R7 ack byte"}, cap[0], 8'hC3);
    if (exp_n == 3 && ncap == 3) begin
      logic [12:0] v;
      v = mem_val(ra);
      rc = ref_crc({19'b0, v}, 13);
      check(cap[1] == v[7:0], {tag, " R8 low byte"}, cap[1], v[7:0]);
      check(cap[2] == {v[12:8], rc}, {tag, " R8 high byte"}, cap[2], {v[12:8], rc});
    end
    if (bad) clear_all();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; sync_ok = 0; byte_vld = 0; byte_data = 0; byte_perr = 0; byte_stop_err = 0;
    byte_start_err = 0; bit_tick = 0; err_clr = 0; rsp_ready = 1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!wr_en && !rd_req && !rsp_vld, "R1 idle outputs", {wr_en, rd_req, rsp_vld}, 0);
    check(err_flags == 0, "R1 flags clear", err_flags, 0);
    send_byte({1'b0, 2'b0, DEV, 1'b0});
    check(!wr_en, "R1 byte before sync ignored", wr_en, 0);

    // directed packets
    run_pkt({1'b0, 2'b0, DEV, 1'b0}, 8'h12, 13'h1ABC, 0, "indiv write R2");
    run_pkt({1'b1, 6'd0, 1'b0}, 8'h34, 13'h0F0F, 0, "global write R5");
    run_pkt({1'b1, CL, 1'b0}, 8'h56, 13'h1FFF, 0, "cluster write R6");
    run_pkt({1'b1, 6'h11, 1'b0}, 8'h56, 13'h0001, 0, "other cluster R6");
    run_pkt({1'b0, 6'h06, 1'b0}, 8'h22, 13'h0123, 0, "other dev write R2");
    run_pkt({1'b0, 2'b0, DEV, 1'b1}, 8'h3C, 13'h0, 0, "indiv read R8");
    run_pkt({1'b1, 6'd0, 1'b1}, 8'h3C, 13'h0, 0, "global read R9");
    run_pkt({1'b0, 6'h07, 1'b1}, 8'h3C, 13'h0, 0, "other read R9");
    run_pkt({1'b0, 2'b0, DEV, 1'b0}, 8'h12, 13'h1ABC, 1, "bad crc R4");

    // R10 parity, stop, start errors
    do_sync(); send_byte({1'b0, 2'b0, DEV, 1'b0}); send_byte(8'h40, 1, 0, 0);
    check(err_flags == 5'b00010, "R10 parity flag", err_flags, 5'b00010);
    send_byte(8'h00); send_byte(8'h00);
    check(!wr_en, "R10 dropped after parity", wr_en, 0);
    do_sync(); send_byte({1'b0, 2'b0, DEV, 1'b0}, 0, 1, 0);
    check(err_flags == 5'b00110, "R10 stop flag", err_flags, 5'b00110);
    do_sync(); send_byte({1'b0, 2'b0, DEV, 1'b0}); send_byte(8'h01, 0, 0, 1);
    check(err_flags == 5'b01110, "R10 start flag", err_flags, 5'b01110);
    // R12 selective clear
    @(negedge clk); err_clr = 5'b00100;
    @(negedge clk); err_clr = 5'b00000;
    check(err_flags == 5'b01010, "R12 clear one bit", err_flags, 5'b01010);
    clear_all();
    check(err_flags == 5'b0, "R12 clear all", err_flags, 0);

    // R11 silence timeout
    do_sync(); send_byte({1'b0, 2'b0, DEV, 1'b0});
    repeat (16) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
    check(err_flags[4] == 0, "R11 16 ticks tolerated", err_flags, 0);
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
    check(err_flags[4] == 1, "R11 17th tick flags", err_flags, 5'b10000);
    send_byte(8'h12); send_byte(8'h00); send_byte(8'h00);
    check(!wr_en, "R11 packet dropped", wr_en, 0);
    clear_all();

    // random packets
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a;
      logic [5:0] id;
      int sel;
      sel = $urandom_range(0, 3);
      id = (sel == 0) ? {2'b0, DEV} : (sel == 1) ? CL : (sel == 2) ? 6'd0 : 6'($urandom);
      a = {1'($urandom), id, 1'($urandom)};
      run_pkt(a, 8'($urandom), 13'($urandom), ($urandom_range(0, 7) == 0), "random R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule